// File: doc/BRIEF.md
# Add/Subtract Integer ALU with Status Flags

This block is the arithmetic core of an integer execute stage. One ripple-carry chain computes either `opa + opb` or `opa - opb`. For subtraction the chain adds the inverted `opb` with a carry-in of one. From the same chain the block derives five status outputs: zero, carry (either as borrow or as not-borrow), signed overflow, sign and signed-less-than. The result and all flags are combinational. The surrounding pipeline reads them in the same cycle, for example to resolve branch conditions or to write back.

The caller can mark an operation as trapping. When a trapping add or subtract overflows in the signed sense, a registered exception strobe is high for one clock after the edge that captured it. Non-trapping operations never raise the strobe. The result is always produced. Dropping the write-back on an exception is left to the pipeline.

The strobe comes from a two-state machine. `EXC_IDLE` is the reset state and holds the strobe low. The transition `EXC_IDLE -> EXC_PULSE` is taken on a clock edge where a trapping operation overflows. In `EXC_PULSE` the strobe is high. `EXC_PULSE -> EXC_PULSE` is taken if the next operation is also a trapping overflow. Otherwise `EXC_PULSE -> EXC_IDLE` is taken. `EXC_IDLE -> EXC_IDLE` is taken whenever no trapping overflow is present.

Top module: `addsub_flags_alu`

## Requirements
- R1: With `sub_sel`=0, `result` equals (`opa` + `opb`) modulo 2^WIDTH.
- R2: With `sub_sel`=1, `result` equals (`opa` - `opb`) modulo 2^WIDTH. It is formed as `opa` + ~`opb` + 1 on the same chain.
- R3: `flag_ovf` is 1 exactly when the signed result falls outside the WIDTH-bit two's complement range. For example, at WIDTH 4, 0111+0001 sets it and 1111+0001 does not.
- R4: On an add, `flag_carry` is the carry out of the top bit, and `borrow_mode` has no effect. On a subtract with `borrow_mode`=1, `flag_carry` is 1 when `opa` < `opb` unsigned, so 1-2 gives 1. On a subtract with `borrow_mode`=0, it is the raw carry out, which is 1 when `opa` >= `opb`.
- R5: `flag_zero` is 1 exactly when every bit of `result` is 0. For example, 1111+0001 at WIDTH 4 sets it.
- R6: `flag_neg` equals bit WIDTH-1 of `result`.
- R7: `flag_lt` is 1 exactly when the true signed value of the operation is negative. On a subtract, this means signed `opa` < signed `opb`, including when overflow occurs. For example, 0x80000000-0x7FFFFFFF gives 1.
- R8: Carry and overflow can be set together. For example, 0x80000000+0xFFFFFFFF gives 0x7FFFFFFF with `flag_carry`=1 and `flag_ovf`=1.
- R9: `exc_pulse` is 1 in the cycle after a clock edge at which `trap_en`=1 and `flag_ovf`=1, and 0 otherwise. An operation with `trap_en`=0 never raises it, whatever the operands.
- R10: While `rst_n` is low and right after reset, `exc_pulse` is 0.
- R11: When a trapping overflow raises `exc_pulse`, `result` still carries the wrapped sum or difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the exception strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand (subtrahend on subtract) |
| sub_sel | input | 1 | 1 = subtract, 0 = add |
| trap_en | input | 1 | 1 = signed overflow raises the exception strobe |
| borrow_mode | input | 1 | 1 = subtract carry flag reports borrow, 0 = reports not-borrow |
| result | output | WIDTH | Sum or difference |
| flag_zero | output | 1 | Result is all zeros |
| flag_carry | output | 1 | Carry out, or borrow on subtract in borrow mode |
| flag_ovf | output | 1 | Signed overflow |
| flag_neg | output | 1 | Sign bit of result |
| flag_lt | output | 1 | True signed result is negative |
| exc_pulse | output | 1 | Registered overflow-exception strobe |

## Verification
The bench builds two copies of the block. One copy at WIDTH 4 receives every operand pair under every combination of subtract, trap and carry convention. That makes the edges of both number ranges, and every case of carry and overflow together, reachable in a few thousand cycles. A second copy at the default WIDTH 32 receives directed corner vectors (the minimum negative value against the maximum positive value, and wrap-around to zero) and random operands. This confirms that the carry chain and the flag logic scale to the full width.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic {
        EXC_IDLE  = 1'b0,
        EXC_PULSE = 1'b1
    } exc_state_e;

    typedef struct packed {
        logic zero;
        logic carry;
        logic ovf;
        logic neg;
        logic lt;
    } alu_flags_t;

endpackage

// File: rtl/addsub_chain.sv
module addsub_chain #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             c_into_msb,
    output logic             c_out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   cy;

    // Invert the subtrahend; the carry-in of one completes the negation.
    assign b_eff = b ^ {WIDTH{sub}};

    always_comb begin
        cy[0] = sub;
        for (int i = 0; i < WIDTH; i++) begin
            sum[i]  = a[i] ^ b_eff[i] ^ cy[i];
            cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
        end
    end

    assign c_into_msb = cy[MSB];
    assign c_out      = cy[WIDTH];
endmodule

// File: rtl/flag_unit.sv
module flag_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] sum,
    input  logic             c_into_msb,
    input  logic             c_out,
    input  logic             sub,
    input  logic             borrow_mode,
    output alu_flags_t       flags
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        flags.zero  = ~|sum;
        // Borrow convention inverts the chain carry on subtract only.
        flags.carry = (sub && borrow_mode) ? ~c_out : c_out;
        flags.ovf   = c_into_msb ^ c_out;
        flags.neg   = sum[MSB];
        flags.lt    = sum[MSB] ^ (c_into_msb ^ c_out);
    end
endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
    import alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trap_en,
    input  logic ovf,
    output logic exc_pulse
);
    exc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EXC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXC_IDLE:  state_d = (trap_en && ovf) ? EXC_PULSE : EXC_IDLE;
            EXC_PULSE: state_d = (trap_en && ovf) ? EXC_PULSE : EXC_IDLE;
            default:   state_d = EXC_IDLE;
        endcase
    end

    always_comb begin
        exc_pulse = (state_q == EXC_PULSE);
    end

    // R9: a strobe only ever follows a trapping overflow
    a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> $past(trap_en && ovf));
    // R9: a non-trapping cycle is never followed by a strobe
    a_r9_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_en |=> !exc_pulse);
endmodule

// File: rtl/addsub_flags_alu.sv
module addsub_flags_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             sub_sel,
    input  logic             trap_en,
    input  logic             borrow_mode,
    output logic [WIDTH-1:0] result,
    output logic             flag_zero,
    output logic             flag_carry,
    output logic             flag_ovf,
    output logic             flag_neg,
    output logic             flag_lt,
    output logic             exc_pulse
);
    localparam int MSB = WIDTH - 1;

    logic       c_into_msb;
    logic       c_out;
    alu_flags_t flags;

    addsub_chain #(.WIDTH(WIDTH)) u_chain (
        .a          (opa),
        .b          (opb),
        .sub        (sub_sel),
        .sum        (result),
        .c_into_msb (c_into_msb),
        .c_out      (c_out)
    );

    flag_unit #(.WIDTH(WIDTH)) u_flags (
        .sum         (result),
        .c_into_msb  (c_into_msb),
        .c_out       (c_out),
        .sub         (sub_sel),
        .borrow_mode (borrow_mode),
        .flags       (flags)
    );

    trap_fsm u_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_en   (trap_en),
        .ovf       (flags.ovf),
        .exc_pulse (exc_pulse)
    );

    assign flag_zero  = flags.zero;
    assign flag_carry = flags.carry;
    assign flag_ovf   = flags.ovf;
    assign flag_neg   = flags.neg;
    assign flag_lt    = flags.lt;

    // R1: ripple chain agrees with a plain adder
    a_r1_add_value: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_sel |-> result == WIDTH'(opa + opb));
    // R2: ripple chain agrees with a plain subtractor
    a_r2_sub_value: assert property (@(posedge clk) disable iff (!rst_n)
        sub_sel |-> result == WIDTH'(opa - opb));
    // R3: overflow needs like-signed addends and a flipped result sign
    a_r3_ovf_same_sign: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ovf |-> (opa[MSB] == (opb[MSB] ^ sub_sel)) && (result[MSB] != opa[MSB]));
    // R4: borrow convention reports unsigned below
    a_r4_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_sel && borrow_mode) |-> flag_carry == (opa < opb));
    // R7: signed less-than on subtract
    a_r7_lt: assert property (@(posedge clk) disable iff (!rst_n)
        sub_sel |-> flag_lt == ($signed(opa) < $signed(opb)));
endmodule

// File: tb/addsub_flags_alu_bench.sv
module addsub_flags_alu_bench;

    typedef struct {
        int          w;
        logic [31:0] res;
        logic        zero, carry, ovf, neg, lt, exc;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    // 32-bit instance
    logic [31:0] a32 = '0, b32 = '0, r32;
    logic s32 = 0, t32 = 0, m32 = 0;
    logic z32, c32, o32, n32, l32, e32;
    // 4-bit instance
    logic [3:0] a4 = '0, b4 = '0, r4;
    logic s4 = 0, t4 = 0, m4 = 0;
    logic z4, c4, o4, n4, l4, e4;

    addsub_flags_alu #(.WIDTH(32)) u_addsub_flags_alu (
        .clk(clk), .rst_n(rst_n), .opa(a32), .opb(b32), .sub_sel(s32),
        .trap_en(t32), .borrow_mode(m32), .result(r32), .flag_zero(z32),
        .flag_carry(c32), .flag_ovf(o32), .flag_neg(n32), .flag_lt(l32),
        .exc_pulse(e32));

    addsub_flags_alu #(.WIDTH(4)) u_addsub_flags_alu_w4 (
        .clk(clk), .rst_n(rst_n), .opa(a4), .opb(b4), .sub_sel(s4),
        .trap_en(t4), .borrow_mode(m4), .result(r4), .flag_zero(z4),
        .flag_carry(c4), .flag_ovf(o4), .flag_neg(n4), .flag_lt(l4),
        .exc_pulse(e4));

    exp_t sb_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    function automatic exp_t model(int w, logic [31:0] a, logic [31:0] b,
                                   logic sub, logic trap, logic bm);
        exp_t   e;
        longint lim, ua, ub, sa, sb, tu, ts;
        lim = longint'(1) << w;
        ua  = longint'(a) & (lim - 1);
        ub  = longint'(b) & (lim - 1);
        sa  = (ua >= lim / 2) ? ua - lim : ua;
        sb  = (ub >= lim / 2) ? ub - lim : ub;
        tu  = sub ? ua - ub : ua + ub;
        ts  = sub ? sa - sb : sa + sb;
        e.w     = w;
        e.res   = 32'(tu & (lim - 1));
        e.zero  = (e.res == 0);
        e.carry = sub ? (bm ? (ua < ub) : (ua >= ub)) : (tu >= lim);
        e.ovf   = (ts >= lim / 2) || (ts < -(lim / 2));
        e.neg   = e.res[w-1];
        e.lt    = (ts < 0);
        e.exc   = trap && e.ovf;
        return e;
    endfunction

    task automatic drive(int w, logic [31:0] a, logic [31:0] b,
                         logic sub, logic trap, logic bm);
        @(negedge clk);
        if (w == 4) begin
            a4 = a[3:0]; b4 = b[3:0]; s4 = sub; t4 = trap; m4 = bm;
        end else begin
            a32 = a; b32 = b; s32 = sub; t32 = trap; m32 = bm;
        end
        sb_q.push_back(model(w, a, b, sub, trap, bm));
    endtask

    task automatic field(string tag, string name, logic [31:0] act,
                         logic [31:0] exp, int w, ref bit bad);
        if (act !== exp) begin
            $display("FAIL %s %s w=%0d actual=%h expected=%h", tag, name, w, act, exp);
            bad = 1;
        end
    endtask

    // Monitor: compare each expected item one edge after it was driven.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t        e;
                logic [31:0] res;
                logic        z, c, o, n, l, x;
                bit          bad;
                e = sb_q.pop_front();
                bad = 0;
                if (e.w == 4) begin
                    res = {28'd0, r4}; z = z4; c = c4; o = o4; n = n4; l = l4; x = e4;
                end else begin
                    res = r32; z = z32; c = c32; o = o32; n = n32; l = l32; x = e32;
                end
                field("R1/R2/R11", "result", res, e.res, e.w, bad);
                field("R5", "zero", {31'd0, z}, {31'd0, e.zero}, e.w, bad);
                field("R4", "carry", {31'd0, c}, {31'd0, e.carry}, e.w, bad);
                field("R3", "ovf", {31'd0, o}, {31'd0, e.ovf}, e.w, bad);
                field("R6", "neg", {31'd0, n}, {31'd0, e.neg}, e.w, bad);
                field("R7", "lt", {31'd0, l}, {31'd0, e.lt}, e.w, bad);
                field("R9", "exc_pulse", {31'd0, x}, {31'd0, e.exc}, e.w, bad);
                n_vec++;
                if (bad) n_fail++;
            end
        end
    end

    initial begin
        #(20 * 200000);
        $display("FAIL watchdog expired");
        n_fail++;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R10: strobe low during reset
        n_vec++;
        if (e32 !== 1'b0 || e4 !== 1'b0) begin
            $display("FAIL R10 exc_pulse in reset actual=%b%b expected=00", e32, e4);
            n_fail++;
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners, WIDTH 4
        drive(4, 32'h7, 32'h1, 0, 1, 0);     // R3 overflow, R9 trap, R11 result kept
        drive(4, 32'hF, 32'h1, 0, 1, 0);     // R3 no overflow, R5 zero
        drive(4, 32'h1, 32'h2, 1, 0, 1);     // R4 borrow=1
        drive(4, 32'h1, 32'h2, 1, 0, 0);     // R4 not-borrow=0
        drive(4, 32'h7, 32'h1, 0, 0, 0);     // R9 non-trapping overflow, no pulse
        // Directed corners, WIDTH 32
        drive(32, 32'h8000_0000, 32'h7FFF_FFFF, 1, 0, 1); // R7 lt with overflow
        drive(32, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0); // R8 carry and overflow
        drive(32, 32'h7FFF_FFFF, 32'h0000_0001, 0, 1, 0); // R9 trap pulse
        drive(32, 32'h7FFF_FFFF, 32'h0000_0001, 0, 1, 0); // R9 back-to-back pulse
        drive(32, 32'h0000_0005, 32'h0000_0003, 0, 0, 0); // R9 pulse ends
        drive(32, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 1); // R5 zero, R4 mode ignored on add

        // Exhaustive WIDTH 4 (R1..R9)
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int m = 0; m < 8; m++)
                    drive(4, 32'(a), 32'(b), m[0], m[1], m[2]);

        // Random WIDTH 32
        for (int k = 0; k < 1500; k++) begin
            logic [31:0] ra, rb, sel;
            ra  = $urandom;
            rb  = $urandom;
            sel = $urandom;
            if (sel[5:4] == 2'b00) rb = ra;              // exercise zero on subtract
            if (sel[7:6] == 2'b00) ra[31:30] = 2'b01;    // bias toward overflow
            drive(32, ra, rb, sel[0], sel[1], sel[2]);
        end

        repeat (4) @(posedge clk);
        #6;
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule